// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches 28 external interrupt inputs. Each input is synchronised to the local clock and then checked against a programmable trigger condition: rising edge, falling edge, either edge, low level or high level. A detected event sets a sticky pending bit. A mask register gates those bits, and the unmasked pending bits are ORed into four group request lines. The group lines feed a downstream vectored interrupt controller.

Software reaches four word registers through a small synchronous write port and a combinational read port. There are two trigger-configuration words, a mask word and a pending word. A pending bit is cleared by writing 1 to it. Each 3-bit trigger field serves a pair of neighbouring lines, so the two lines of a pair always trigger the same way.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every trigger field holds 100 (rising edge), all 28 mask bits are 1, all pending bits are 0 and all four group outputs are 0. So a read returns 0x44444444 at word 0, 0x00444444 at word 1, 0x0FFFFFFF at word 2 and 0 at word 3.
- R2: Word 0 holds trigger fields for lines 0 to 15 and word 1 holds them for lines 16 to 27. Field k sits in bits 4k+2..4k, and bit 4k+3 always reads 0. In word 1 only fields 0 to 5 exist: bits 31..24 read 0 and writes to them are dropped. Bits 31..28 of the mask and pending words read 0.
- R3: Field codes 01x, 10x and 11x select falling edge, rising edge and both edges. A matching transition sets the line's pending bit, and the opposite transition in a single-edge mode does not.
- R4: Field code 000 selects low level and 001 selects high level. The pending bit sets while the level is active and stays set through a clear write for as long as the level remains active.
- R5: Field k of word 0 serves lines 2k and 2k+1, and field k of word 1 serves lines 16+2k and 17+2k. Both lines of a pair follow the same mode.
- R6: Writing word 3 clears each pending bit written with 1 and leaves every bit written with 0 unchanged. A pending bit is never cleared in any other way.
- R7: When a new event and a clear write hit the same pending bit in the same cycle, the bit stays set.
- R8: Pending bits latch whether or not their line is masked. Mask bit 1 blocks the line and mask bit 0 passes it, and the mask only gates the group outputs.
- R9: Group output 0 covers lines 0-3, output 1 covers lines 4-11, output 2 covers lines 12-19 and output 3 covers lines 20-27. Each output is high exactly when some line in its range is pending with mask 0.
- R10: An input change driven between two clock edges shows in the pending register after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released in step with the clock |
| line_i | input | 28 | Asynchronous external interrupt inputs |
| bus_we_i | input | 1 | Register write strobe, taken on the rising clock edge |
| bus_addr_i | input | 2 | Word select: 0 and 1 trigger configuration, 2 mask, 3 pending |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected word (combinational) |
| irq_grp_o | output | 4 | Group interrupt requests |

## Verification
The main sweep runs every line through all eight field codes. For each code it drives an idle level, an active transition, a clear while active, a release and a final clear. This separates edge modes from level modes, rising from falling, and the don't-care low bit of the edge codes. Because the partner line is held low, the low-level runs also show that a pair shares one field. Masking a line after it latched separates pending capture from output gating. The group expected at each step shows whether the line is folded onto the correct output. Two directed cases time the input-to-pending latency edge by edge and land a clear write in the same cycle as a fresh edge.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int unsigned EXT_LINES = 28;
  localparam int unsigned EXT_GRPS  = 4;
  localparam int unsigned BUS_DW    = 32;
  localparam int unsigned FIELD_W   = 3;
  localparam int unsigned FIELD_PITCH = 4;
  localparam int unsigned LO_PAIRS  = 8;

  // first line of each group, with a closing bound
  localparam int unsigned GRP_BOUND [EXT_GRPS+1] = '{0, 4, 12, 20, 28};

  typedef logic [FIELD_W-1:0] trig_t;

  localparam trig_t TRIG_LOW  = 3'b000;
  localparam trig_t TRIG_HIGH = 3'b001;
  localparam trig_t TRIG_RISE = 3'b100;

  typedef enum logic [1:0] {
    W_CFG_LO = 2'd0,
    W_CFG_HI = 2'd1,
    W_MASK   = 2'd2,
    W_PEND   = 2'd3
  } word_e;

  function automatic int unsigned grp_of(int unsigned line);
    int unsigned g;
    g = 0;
    for (int unsigned k = 1; k < EXT_GRPS; k++) begin
      if (line >= GRP_BOUND[k]) g = k;
    end
    return g;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned W      = 28,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  trig_t mode_i,
  output logic  evt_o
);

  logic prv_q, prv_d;
  logic is_level, want_rise, want_fall;

  assign prv_d = lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prv_q <= 1'b0;
    else         prv_q <= prv_d;
  end

  always_comb begin
    is_level  = (mode_i[2:1] == 2'b00);
    want_rise = mode_i[2];
    want_fall = mode_i[1];
    if (is_level) begin
      evt_o = mode_i[0] ? lvl_i : ~lvl_i;
    end else begin
      evt_o = (want_rise & lvl_i & ~prv_q) | (want_fall & ~lvl_i & prv_q);
    end
  end

  // R3: an edge-mode event needs the synchronised input to have moved
  p_edge_needs_change_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2:1] != 2'b00 && evt_o) |-> (lvl_i != $past(lvl_i)));

endmodule

// File: rtl/extint_group.sv
module extint_group
  import extint_pkg::*;
#(
  parameter int unsigned LINES = EXT_LINES,
  parameter int unsigned GRPS  = EXT_GRPS
) (
  input  logic [LINES-1:0] act_i,
  output logic [GRPS-1:0]  irq_o
);

  for (genvar g = 0; g < GRPS; g++) begin : g_grp
    always_comb begin
      irq_o[g] = 1'b0;
      for (int unsigned l = 0; l < LINES; l++) begin
        if (grp_of(l) == g) irq_o[g] = irq_o[g] | act_i[l];
      end
    end
  end

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned LINES       = EXT_LINES,
  parameter int unsigned GRPS        = EXT_GRPS,
  parameter int unsigned DW          = BUS_DW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic [GRPS-1:0]  irq_grp_o
);

  localparam int unsigned PAIRS = (LINES + 1) / 2;

  logic [LINES-1:0] lvl_s;
  logic [LINES-1:0] evt;
  logic [LINES-1:0] clr_vec;
  logic [LINES-1:0] mask_q, mask_d;
  logic [LINES-1:0] pend_q, pend_d;
  trig_t            cfg_q [PAIRS];
  trig_t            cfg_d [PAIRS];
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata_i;

  extint_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_i),
    .q_o    (lvl_s)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_det
    extint_detect u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl_s[l]),
      .mode_i (cfg_q[l/2]),
      .evt_o  (evt[l])
    );
  end

  // ---------------- next state ----------------
  always_comb begin
    for (int k = 0; k < PAIRS; k++) begin
      cfg_d[k] = cfg_q[k];
      if (k < LO_PAIRS) begin
        if (bus_we_i && bus_addr_i == W_CFG_LO)
          cfg_d[k] = bus_wdata_i[FIELD_PITCH*k +: FIELD_W];
      end else begin
        if (bus_we_i && bus_addr_i == W_CFG_HI)
          cfg_d[k] = bus_wdata_i[FIELD_PITCH*(k-LO_PAIRS) +: FIELD_W];
      end
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (bus_we_i && bus_addr_i == W_MASK) mask_d = bus_wdata_i[LINES-1:0];
  end

  assign clr_vec = (bus_we_i && bus_addr_i == W_PEND) ? bus_wdata_i[LINES-1:0] : '0;

  // a fresh event outranks a clear on the same bit
  assign pend_d = (pend_q & ~clr_vec) | evt;

  // ---------------- registers ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < PAIRS; k++) cfg_q[k] <= TRIG_RISE;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      for (int k = 0; k < PAIRS; k++) cfg_q[k] <= cfg_d[k];
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      W_CFG_LO: for (int k = 0; k < LO_PAIRS; k++)
                  bus_rdata_o[FIELD_PITCH*k +: FIELD_W] = cfg_q[k];
      W_CFG_HI: for (int k = LO_PAIRS; k < PAIRS; k++)
                  bus_rdata_o[FIELD_PITCH*(k-LO_PAIRS) +: FIELD_W] = cfg_q[k];
      W_MASK:   bus_rdata_o[LINES-1:0] = mask_q;
      default:  bus_rdata_o[LINES-1:0] = pend_q;
    endcase
  end

  extint_group #(.LINES(LINES), .GRPS(GRPS)) u_grp (
    .act_i (pend_q & ~mask_q),
    .irq_o (irq_grp_o)
  );

  // R7: every event of a cycle is pending in the next one
  p_event_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(evt)) == $past(evt)));

  // R6: a pending bit only falls when written with 1
  p_clear_only_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0));

  // R9: a group request needs an unmasked pending line
  p_irq_needs_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_grp_o != '0) |-> ((pend_q & ~mask_q) != '0));

  // R8: writing the mask never moves a pending bit
  p_mask_keeps_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == W_MASK && evt == '0) |=> (pend_q == $past(pend_q)));

endmodule

// File: tb/tb_extint_ctrl.sv
`timescale 1ns/1ps
module tb_extint_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] ein = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;   // 250 MHz

  extint_ctrl dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_i      (ein),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_grp_o   (irq)
  );

  localparam int C_LOW = 0, C_HIGH = 1, C_FALL = 2, C_RISE = 3, C_BOTH = 4;

  function automatic int cls_of(logic [2:0] c);
    case (c)
      3'b000: return C_LOW;
      3'b001: return C_HIGH;
      3'b010, 3'b011: return C_FALL;
      3'b100, 3'b101: return C_RISE;
      default: return C_BOTH;
    endcase
  endfunction

  function automatic int grp(int l);
    return (l < 4) ? 0 : (l < 12) ? 1 : (l < 20) ? 2 : 3;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic run_case(int i, logic [2:0] code);
    int cls = cls_of(code);
    int p = i ^ 1;
    logic [27:0] bi = 28'd1 << i;
    logic [27:0] bp = 28'd1 << p;
    logic idle = (cls == C_FALL || cls == C_LOW);
    logic [31:0] v, rd;
    logic [27:0] exp;
    v = (i < 16) ? 32'h44444444 : 32'h00444444;
    v[4*((i % 16)/2) +: 3] = code;
    ein[i] = idle;
    waitn(4);
    wr((i < 16) ? 2'd0 : 2'd1, v);
    waitn(4);
    wr(2'd3, 32'h0FFFFFFF);
    waitn(2);
    exp = (cls == C_LOW) ? bp : '0;
    peek(2'd3, rd); chk("R5 pair shares field (idle)", rd, {4'b0, exp});
    ein[i] = ~idle;
    waitn(4);
    exp |= bi;
    peek(2'd3, rd); chk((cls <= C_HIGH) ? "R4 level sets" : "R3 edge sets", rd, {4'b0, exp});
    chk("R9 group output", {28'b0, irq}, 32'd1 << grp(i));
    wr(2'd2, {4'b0, bi | bp});
    chk("R8 mask gates group", {28'b0, irq}, 32'd0);
    peek(2'd3, rd); chk("R8 pending kept under mask", rd, {4'b0, exp});
    wr(2'd2, 32'd0);
    wr(2'd3, {4'b0, bi});
    waitn(2);
    if (cls > C_HIGH) exp &= ~bi;
    peek(2'd3, rd); chk((cls <= C_HIGH) ? "R4 held while active" : "R6 w1c clears", rd, {4'b0, exp});
    ein[i] = idle;
    waitn(4);
    if (cls == C_BOTH) exp |= bi;
    peek(2'd3, rd); chk("R3 return transition", rd, {4'b0, exp});
    wr(2'd3, {4'b0, bi});
    waitn(2);
    exp &= ~bi;
    peek(2'd3, rd); chk("R6 w1c after release", rd, {4'b0, exp});
    wr(2'd0, 32'h44444444);
    wr(2'd1, 32'h00444444);
    ein[i] = 1'b0;
    waitn(4);
    wr(2'd3, 32'h0FFFFFFF);
    waitn(2);
    peek(2'd3, rd); chk("R6 clear all", rd, 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    waitn(3);
    rst_n = 1'b1;
    waitn(2);

    // R1 reset state
    peek(2'd0, rd); chk("R1 cfg word 0", rd, 32'h44444444);
    peek(2'd1, rd); chk("R1 cfg word 1", rd, 32'h00444444);
    peek(2'd2, rd); chk("R1 mask", rd, 32'h0FFFFFFF);
    peek(2'd3, rd); chk("R1 pending", rd, 32'h0);
    chk("R1 groups", {28'b0, irq}, 32'h0);

    // R2 layout and reserved bits (both-edge everywhere: no events with lines low)
    wr(2'd0, 32'hFFFFFFFF);
    peek(2'd0, rd); chk("R2 word 0 fields", rd, 32'h77777777);
    wr(2'd1, 32'hFFFFFFFF);
    peek(2'd1, rd); chk("R2 word 1 fields", rd, 32'h00777777);
    wr(2'd2, 32'hFFFFFFFF);
    peek(2'd2, rd); chk("R2 mask width", rd, 32'h0FFFFFFF);
    wr(2'd0, 32'h44444444);
    wr(2'd1, 32'h00444444);
    wr(2'd2, 32'h0);
    peek(2'd2, rd); chk("R2 mask write", rd, 32'h0);

    // full sweep: every line, every field code
    for (int i = 0; i < 28; i++) begin
      for (int c = 0; c < 8; c++) run_case(i, 3'(c));
    end

    // R10 latency, line 6 rising
    @(negedge clk); ein[6] = 1'b1;
    @(negedge clk); @(negedge clk);
    peek(2'd3, rd); chk("R10 not after second edge", rd, 32'h0);
    @(negedge clk);
    peek(2'd3, rd); chk("R10 set after third edge", rd, 32'h40);
    ein[6] = 1'b0;
    wr(2'd3, 32'h40);
    waitn(2);

    // R7 event and clear in the same cycle, line 5 rising
    @(negedge clk); ein[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    we = 1'b1; addr = 2'd3; wdata = 32'h20;
    @(negedge clk); we = 1'b0;
    peek(2'd3, rd); chk("R7 event wins over clear", rd, 32'h20);
    wr(2'd3, 32'h20);
    peek(2'd3, rd); chk("R6 clear on next write", rd, 32'h0);
    ein[5] = 1'b0;
    waitn(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule